// File: doc/BRIEF.md
# Temperature-Compensation Trim Controller

This block turns a stream of temperature samples into a capacitance trim code for an oscillator's tuning DAC. Each 12-bit two's-complement sample, at 1/16 degree per LSB, selects a pair of adjacent entries in a calibration table whose entries are half a degree apart. The block reads both entries through a synchronous table port and interpolates linearly between them using the three sub-interval bits of the sample. It adds a signed user tuning offset and loads the saturated sum into the DAC code register, with a one-cycle load pulse.

Work is done only when needed. A computation starts when the latest sample differs from the one last used, or when the low byte of the tuning register is written. A freeze bit in the tuning register stops the temperature-derived trim from following the sensor. The held trim stays in use and tuning writes still reach the DAC. A small byte-wide register port holds the tuning value and reads back the most recent temperature sample.

Top module: `temp_trim_ctrl`

## Requirements
- R1: After reset the tuning value, freeze bit and temperature readback are all zero, the DAC code is 0, and no load pulse is issued.
- R2: A table computation starts only when freeze is clear and the latest sample differs from the sample last used, or no sample has been used yet. Repeating the same sample causes no load.
- R3: The first table address is the sample's upper 9 bits with the top bit inverted (offset binary, 0 for -128 degrees, 511 for the highest interval). The second address is the first plus one, except at 511, where the same entry is read again. The table returns data one cycle after the read strobe.
- R4: The trim is A + floor((B - A) * f / 8), where A and B are the first and second entries and f is sample bits 2..0, computed in signed arithmetic.
- R5: The DAC code is trim plus the sign-extended tuning value, clamped to the range 0..65535 instead of wrapping.
- R6: Register 0 holds the freeze flag in bit 7 and tuning bits 14..8 in bits 6..0, where bit 6 is the sign. Register 1 holds tuning bits 7..0. Together they form a 15-bit two's-complement value, and both registers read back as written.
- R7: A write to register 1 causes one load that adds the current tuning value to the held trim. A write to register 0 alone causes no load.
- R8: While freeze is 1, new samples start no table read and the held trim does not change, but tuning writes still load the DAC. Once freeze is cleared, a sample that differs from the last used one is computed.
- R9: Every valid sample is captured for readback, whatever the freeze state. Register 2 reads sample bits 11..4, and register 3 reads sample bits 3..0 in bits 7..4 with bits 3..0 zero. Writes to registers 2 and 3 are ignored.
- R10: When the block is idle, the load pulse follows 5 clock edges after the edge that samples a changed temperature, and 2 edges after a register-1 write edge. The pulse lasts one cycle, and the DAC code changes only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | 12 | Temperature sample, two's complement, 1/16 degree per LSB |
| temp_valid_i | input | 1 | Sample strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| tbl_rd_o | output | 1 | Calibration table read strobe |
| tbl_addr_o | output | 9 | Calibration table address |
| tbl_data_i | input | 16 | Calibration entry, valid the cycle after the strobe |
| dac_code_o | output | 16 | DAC code register |
| dac_load_o | output | 1 | One-cycle pulse with each DAC code load |

## Verification
A changed temperature goes through sample capture, two table reads, interpolation and the load stage, so its load pulse is due five edges after the sampling edge. A register-1 write skips the table, so its pulse is due two edges after the write edge. The bench counts falling edges from the end of each stimulus and compares that count with these exact numbers before it compares the code. Cases that must not load are watched over a window well longer than five cycles. Register readback is sampled on the falling edge, away from any write.

// File: rtl/temp_trim_pkg.sv
`timescale 1ns/1ps
package temp_trim_pkg;

    // Tuning value width is fixed by the two-byte register layout.
    localparam int TUNE_W = 15;

    localparam logic [1:0] REG_TUNE_HI = 2'd0;
    localparam logic [1:0] REG_TUNE_LO = 2'd1;
    localparam logic [1:0] REG_TEMP_HI = 2'd2;
    localparam logic [1:0] REG_TEMP_LO = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_INTERP,
        ST_LOAD
    } trim_state_e;

endpackage

// File: rtl/temp_trim_regs.sv
`timescale 1ns/1ps
module temp_trim_regs
    import temp_trim_pkg::*;
#(
    parameter int TEMP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [1:0]               wr_addr_i,
    input  logic [7:0]               wr_data_i,
    input  logic [1:0]               rd_addr_i,
    output logic [7:0]               rd_data_o,
    input  logic                     temp_valid_i,
    input  logic [TEMP_W-1:0]        temp_i,
    input  logic                     pend_clr_i,
    output logic                     freeze_o,
    output logic signed [TUNE_W-1:0] tune_o,
    output logic [TEMP_W-1:0]        temp_o,
    output logic                     seen_o,
    output logic                     pend_o
);

    localparam int PAD_W = 16 - TEMP_W;

    typedef struct packed {
        logic              freeze;
        logic [TUNE_W-1:0] tune;
        logic [TEMP_W-1:0] temp;
        logic              seen;
        logic              pend;
    } regs_t;

    regs_t r_d, r_q;
    logic [15:0] temp_rb;

    always_comb begin
        r_d      = r_q;
        r_d.pend = r_q.pend & ~pend_clr_i;
        if (wr_en_i) begin
            if (wr_addr_i == REG_TUNE_HI) begin
                r_d.freeze           = wr_data_i[7];
                r_d.tune[TUNE_W-1:8] = wr_data_i[TUNE_W-9:0];
            end else if (wr_addr_i == REG_TUNE_LO) begin
                r_d.tune[7:0] = wr_data_i;
                r_d.pend      = 1'b1;
            end
        end
        if (temp_valid_i) begin
            r_d.temp = temp_i;
            r_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign temp_rb = {r_q.temp, {PAD_W{1'b0}}};

    always_comb begin
        case (rd_addr_i)
            REG_TUNE_HI: rd_data_o = {r_q.freeze, r_q.tune[TUNE_W-1:8]};
            REG_TUNE_LO: rd_data_o = r_q.tune[7:0];
            REG_TEMP_HI: rd_data_o = temp_rb[15:8];
            default:     rd_data_o = temp_rb[7:0];
        endcase
    end

    assign freeze_o = r_q.freeze;
    assign tune_o   = $signed(r_q.tune);
    assign temp_o   = r_q.temp;
    assign seen_o   = r_q.seen;
    assign pend_o   = r_q.pend;

endmodule

// File: rtl/temp_trim_interp.sv
`timescale 1ns/1ps
module temp_trim_interp #(
    parameter int TRIM_W = 16,
    parameter int FRAC_W = 3
) (
    input  logic [TRIM_W-1:0] a_i,
    input  logic [TRIM_W-1:0] b_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [TRIM_W-1:0] trim_o
);

    localparam int PW = TRIM_W + FRAC_W + 3;

    logic signed [TRIM_W+1:0] a_s, b_s, diff;
    logic signed [FRAC_W:0]   frac_s;
    logic signed [PW-1:0]     base, prod, acc, full;
    logic signed [PW-1:0]     trim_max;

    assign a_s    = $signed({2'b00, a_i});
    assign b_s    = $signed({2'b00, b_i});
    assign diff   = b_s - a_s;
    assign frac_s = $signed({1'b0, frac_i});

    // Scale A by the interval so the floor of the sum equals A + floor(step).
    assign base     = PW'(a_s) <<< FRAC_W;
    assign prod     = PW'(diff) * PW'(frac_s);
    assign acc      = base + prod;
    assign full     = acc >>> FRAC_W;
    assign trim_max = $signed({{(PW-TRIM_W){1'b0}}, {TRIM_W{1'b1}}});

    always_comb begin
        if (full[PW-1])           trim_o = '0;
        else if (full > trim_max) trim_o = '1;
        else                      trim_o = full[TRIM_W-1:0];
    end

endmodule

// File: rtl/temp_trim_sat_add.sv
`timescale 1ns/1ps
module temp_trim_sat_add
    import temp_trim_pkg::*;
#(
    parameter int TRIM_W = 16,
    parameter int DAC_W  = 16
) (
    input  logic [TRIM_W-1:0]        trim_i,
    input  logic signed [TUNE_W-1:0] tune_i,
    output logic [DAC_W-1:0]         code_o
);

    localparam int W1    = (TRIM_W > DAC_W) ? TRIM_W : DAC_W;
    localparam int W2    = (W1 > TUNE_W) ? W1 : TUNE_W;
    localparam int SUM_W = W2 + 2;

    logic signed [SUM_W-1:0] sum_s;
    logic signed [SUM_W-1:0] code_max;

    assign sum_s    = $signed({{(SUM_W-TRIM_W){1'b0}}, trim_i}) + SUM_W'(tune_i);
    assign code_max = $signed({{(SUM_W-DAC_W){1'b0}}, {DAC_W{1'b1}}});

    always_comb begin
        if (sum_s[SUM_W-1])        code_o = '0;
        else if (sum_s > code_max) code_o = '1;
        else                       code_o = sum_s[DAC_W-1:0];
    end

endmodule

// File: rtl/temp_trim_ctrl.sv
`timescale 1ns/1ps
module temp_trim_ctrl
    import temp_trim_pkg::*;
#(
    parameter int TEMP_W = 12,
    parameter int FRAC_W = 3,
    parameter int TRIM_W = 16,
    parameter int DAC_W  = 16,
    localparam int TBL_AW = TEMP_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              tbl_rd_o,
    output logic [TBL_AW-1:0] tbl_addr_o,
    input  logic [TRIM_W-1:0] tbl_data_i,
    output logic [DAC_W-1:0]  dac_code_o,
    output logic              dac_load_o
);

    typedef struct packed {
        trim_state_e       st;
        logic [TEMP_W-1:0] used;
        logic              used_ok;
        logic [TRIM_W-1:0] a;
        logic [TRIM_W-1:0] trim;
        logic [DAC_W-1:0]  dac;
        logic              load;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                     freeze;
    logic signed [TUNE_W-1:0] tune;
    logic [TEMP_W-1:0]        temp_cur;
    logic                     temp_seen;
    logic                     tune_pend;
    logic                     pend_clr;
    logic [TBL_AW-1:0]        addr_a, addr_b;
    logic [TRIM_W-1:0]        interp_trim;
    logic [DAC_W-1:0]         sat_code;
    logic                     temp_new;

    temp_trim_regs #(.TEMP_W(TEMP_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .temp_valid_i (temp_valid_i),
        .temp_i       (temp_i),
        .pend_clr_i   (pend_clr),
        .freeze_o     (freeze),
        .tune_o       (tune),
        .temp_o       (temp_cur),
        .seen_o       (temp_seen),
        .pend_o       (tune_pend)
    );

    temp_trim_interp #(.TRIM_W(TRIM_W), .FRAC_W(FRAC_W)) u_interp (
        .a_i    (c_q.a),
        .b_i    (tbl_data_i),
        .frac_i (c_q.used[FRAC_W-1:0]),
        .trim_o (interp_trim)
    );

    temp_trim_sat_add #(.TRIM_W(TRIM_W), .DAC_W(DAC_W)) u_sat (
        .trim_i (c_q.trim),
        .tune_i (tune),
        .code_o (sat_code)
    );

    // Offset-binary interval index; the top interval reuses its own entry.
    assign addr_a = {~c_q.used[TEMP_W-1], c_q.used[TEMP_W-2:FRAC_W]};
    assign addr_b = (&addr_a) ? addr_a : addr_a + 1'b1;

    assign temp_new = temp_seen && (!c_q.used_ok || (temp_cur != c_q.used));
    assign pend_clr = (c_q.st == ST_LOAD);

    always_comb begin
        c_d      = c_q;
        c_d.load = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (!freeze && temp_new) begin
                    c_d.st      = ST_RD_A;
                    c_d.used    = temp_cur;
                    c_d.used_ok = 1'b1;
                end else if (tune_pend) begin
                    c_d.st = ST_LOAD;
                end
            end
            ST_RD_A: c_d.st = ST_RD_B;
            ST_RD_B: begin
                c_d.a  = tbl_data_i;
                c_d.st = ST_INTERP;
            end
            ST_INTERP: begin
                c_d.trim = interp_trim;
                c_d.st   = ST_LOAD;
            end
            ST_LOAD: begin
                c_d.dac  = sat_code;
                c_d.load = 1'b1;
                c_d.st   = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign tbl_rd_o   = (c_q.st == ST_RD_A) || (c_q.st == ST_RD_B);
    assign tbl_addr_o = (c_q.st == ST_RD_B) ? addr_b : addr_a;
    assign dac_code_o = c_q.dac;
    assign dac_load_o = c_q.load;

endmodule

// File: rtl/temp_trim_ctrl_chk.sv
`timescale 1ns/1ps
module temp_trim_ctrl_chk #(
    parameter int TEMP_W = 12,
    parameter int TBL_AW = 9,
    parameter int DAC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dac_load_o,
    input logic [DAC_W-1:0]  dac_code_o,
    input logic              tbl_rd_o,
    input logic [TBL_AW-1:0] tbl_addr_o,
    input logic [1:0]        rd_addr_i,
    input logic [7:0]        rd_data_o,
    input logic              freeze
);

    localparam int PAD_W = 16 - TEMP_W;

    // R10
    load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load_o |=> !dac_load_o);

    // R10
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code_o != $past(dac_code_o)) |-> dac_load_o);

    // R3
    tbl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_o && $past(tbl_rd_o)) |->
            ((tbl_addr_o == $past(tbl_addr_o) + 1'b1) ||
             ((tbl_addr_o == $past(tbl_addr_o)) && (&tbl_addr_o))));

    // R8
    freeze_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbl_rd_o) |-> !$past(freeze));

    // R9
    temp_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 2'd3) |-> (rd_data_o[PAD_W-1:0] == '0));

endmodule

bind temp_trim_ctrl temp_trim_ctrl_chk #(
    .TEMP_W (TEMP_W),
    .TBL_AW (TBL_AW),
    .DAC_W  (DAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_load_o (dac_load_o),
    .dac_code_o (dac_code_o),
    .tbl_rd_o   (tbl_rd_o),
    .tbl_addr_o (tbl_addr_o),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .freeze     (freeze)
);

// File: tb/temp_trim_ctrl_bench.sv
`timescale 1ns/1ps
module temp_trim_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] temp_i = '0;
    logic        temp_valid_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [1:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        tbl_rd_o;
    logic [8:0]  tbl_addr_o;
    logic [15:0] tbl_data_i = '0;
    logic [15:0] dac_code_o;
    logic        dac_load_o;

    int n_checks = 0;
    int n_errors = 0;
    int tbl_mode = 0;
    int cur_trim = 0;
    int cur_tune = 0;

    always #10 clk = ~clk;

    temp_trim_ctrl u_temp_trim_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_i       (temp_i),
        .temp_valid_i (temp_valid_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .tbl_rd_o     (tbl_rd_o),
        .tbl_addr_o   (tbl_addr_o),
        .tbl_data_i   (tbl_data_i),
        .dac_code_o   (dac_code_o),
        .dac_load_o   (dac_load_o)
    );

    function automatic int tbl_f(int a);
        if (tbl_mode == 0)      return 30000 + 40 * a - (a % 2) * 75;
        else if (tbl_mode == 1) return 2 * a;
        else                    return 65535 - a;
    endfunction

    // Calibration table model: synchronous, one cycle of latency.
    always @(posedge clk)
        if (tbl_rd_o) tbl_data_i <= 16'(tbl_f(int'(tbl_addr_o)));

    function automatic int exp_trim(logic [11:0] t);
        int idx = int'($signed(t[11:3]));
        int fr  = int'(t[2:0]);
        int a   = idx + 256;
        int b   = (a == 511) ? 511 : a + 1;
        int d   = (tbl_f(b) - tbl_f(a)) * fr;
        return tbl_f(a) + (d >>> 3);
    endfunction

    function automatic int exp_code(int trim, int tune);
        int s = trim + tune;
        if (s < 0) return 0;
        if (s > 65535) return 65535;
        return s;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_temp(logic [11:0] t);
        @(negedge clk);
        temp_i = t;
        temp_valid_i = 1'b1;
        @(negedge clk);
        temp_valid_i = 1'b0;
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rreg(logic [1:0] a, output int d);
        rd_addr_i = a;
        #1;
        d = int'(rd_data_o);
    endtask

    task automatic wait_load(output int cyc, output int code);
        cyc = -1;
        code = -1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (dac_load_o) begin
                cyc = k;
                code = int'(dac_code_o);
                break;
            end
        end
    endtask

    task automatic count_loads(int n, output int loads);
        loads = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (dac_load_o) loads++;
        end
    endtask

    task automatic t_reset();
        int d;
        chk("R1 dac code", int'(dac_code_o), 0);
        chk("R1 load pulse", int'(dac_load_o), 0);
        for (int r = 0; r < 4; r++) begin
            rreg(2'(r), d);
            chk("R1 register reset", d, 0);
        end
    endtask

    task automatic t_first_temp();
        int cyc, code;
        send_temp(12'h190);
        cur_trim = exp_trim(12'h190);
        wait_load(cyc, code);
        chk("R10 temperature latency", cyc, 5);
        chk("R4 integer point code", code, exp_code(cur_trim, cur_tune));
    endtask

    task automatic t_repeat();
        int loads;
        send_temp(12'h190);
        count_loads(12, loads);
        chk("R2 repeated sample no load", loads, 0);
    endtask

    task automatic t_interp();
        int cyc, code;
        send_temp(12'h193);
        cur_trim = exp_trim(12'h193);
        wait_load(cyc, code);
        chk("R4 falling slope floor", code, exp_code(cur_trim, cur_tune));
        send_temp(12'h19D);
        cur_trim = exp_trim(12'h19D);
        wait_load(cyc, code);
        chk("R4 rising slope floor", code, exp_code(cur_trim, cur_tune));
    endtask

    task automatic t_tune();
        int cyc, code, loads, d;
        wreg(2'd0, 8'h01);
        count_loads(10, loads);
        chk("R7 high byte alone no load", loads, 0);
        wreg(2'd1, 8'h23);
        cur_tune = 291;
        wait_load(cyc, code);
        chk("R10 tune latency", cyc, 2);
        chk("R7 positive tune applied", code, exp_code(cur_trim, cur_tune));
        rreg(2'd0, d);
        chk("R6 high byte readback", d, 8'h01);
        rreg(2'd1, d);
        chk("R6 low byte readback", d, 8'h23);
        wreg(2'd0, 8'h7F);
        wreg(2'd1, 8'h00);
        cur_tune = -256;
        wait_load(cyc, code);
        chk("R6 negative tune", code, exp_code(cur_trim, cur_tune));
    endtask

    task automatic t_readback();
        int cyc, code, d, loads;
        send_temp(12'hFF5);
        cur_trim = exp_trim(12'hFF5);
        wait_load(cyc, code);
        chk("R3 negative temperature code", code, exp_code(cur_trim, cur_tune));
        rreg(2'd2, d);
        chk("R9 temperature high byte", d, 8'hFF);
        rreg(2'd3, d);
        chk("R9 temperature low byte", d, 8'h50);
        wreg(2'd2, 8'h12);
        wreg(2'd3, 8'h34);
        count_loads(8, loads);
        chk("R9 read-only write no load", loads, 0);
        rreg(2'd2, d);
        chk("R9 write to reg 2 ignored", d, 8'hFF);
        rreg(2'd3, d);
        chk("R9 write to reg 3 ignored", d, 8'h50);
    endtask

    task automatic t_freeze();
        int cyc, code, loads, d;
        wreg(2'd0, 8'h80);
        cur_tune = 0;
        count_loads(8, loads);
        chk("R8 freeze write no load", loads, 0);
        send_temp(12'h0A0);
        count_loads(12, loads);
        chk("R8 frozen sample no load", loads, 0);
        rreg(2'd2, d);
        chk("R9 frozen capture high", d, 8'h0A);
        rreg(2'd3, d);
        chk("R9 frozen capture low", d, 8'h00);
        wreg(2'd1, 8'h10);
        cur_tune = 16;
        wait_load(cyc, code);
        chk("R8 tune on frozen trim latency", cyc, 2);
        chk("R8 tune on frozen trim", code, exp_code(cur_trim, cur_tune));
        wreg(2'd0, 8'h00);
        cur_trim = exp_trim(12'h0A0);
        wait_load(cyc, code);
        chk("R8 unfreeze latency", cyc, 5);
        chk("R8 unfreeze recompute", code, exp_code(cur_trim, cur_tune));
    endtask

    task automatic t_bounds();
        int cyc, code;
        wreg(2'd0, 8'h3F);
        wreg(2'd1, 8'hFF);
        cur_tune = 16383;
        wait_load(cyc, code);
        chk("R5 max tune no clamp", code, exp_code(cur_trim, cur_tune));
        tbl_mode = 2;
        send_temp(12'h7FF);
        cur_trim = exp_trim(12'h7FF);
        wait_load(cyc, code);
        chk("R3 top interval trim", cur_trim, 65024);
        chk("R5 clamp high", code, 65535);
        tbl_mode = 1;
        wreg(2'd0, 8'h40);
        wreg(2'd1, 8'h00);
        cur_tune = -16384;
        wait_load(cyc, code);
        chk("R6 minimum tune", code, exp_code(cur_trim, cur_tune));
        send_temp(12'h800);
        cur_trim = exp_trim(12'h800);
        wait_load(cyc, code);
        chk("R5 clamp low", code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_temp();
        t_repeat();
        t_interp();
        t_tune();
        t_readback();
        t_freeze();
        t_bounds();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule